// File: doc/BRIEF.md
# Seeded Three-Phase Johnson Test Pattern Generator

This block is a built-in self-test stimulus source. It holds an n-bit pattern register whose per-bit input is chosen by a single four-way selector. The selector picks one of four actions: keep the value, take a seed in parallel, rotate as a plain ring, or rotate with the wrap-around bit inverted (twisted ring, also called a Johnson counter). A small seed table is fixed at elaboration time through a parameter.

A one-cycle pulse on `start_i` launches a sweep through the whole table in ascending order. Each seed first takes one parallel-load cycle, during which no pattern is flagged. It is then clocked autonomously for 3n cycles. The first n steps use the plain ring and the remaining 2n steps use the twisted ring, so the mode changes exactly once per seed. Every cycle of a run presents one pattern on `pattern_o` with `valid_o` high, so the core under test receives a new stimulus each clock.

After the last seed's run the block raises `done_o` and the register holds its value until the next start. Response compaction and the choice of seeds are handled elsewhere.

Top module: `tpg_johnson_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `valid_o` and `done_o` are 0 and `pattern_o` is all zeros.
- R2: The clock edge that samples `start_i` high is followed by exactly one load cycle with `valid_o` low. The next cycle shows seed 0 with `valid_o` high. Seed k is the slice `SEED_TABLE[k*WIDTH +: WIDTH]`.
- R3: Each seed yields exactly 3·WIDTH consecutive cycles with `valid_o` high, and the first pattern of each run equals that seed.
- R4: For run patterns 1 through WIDTH, each pattern is the previous one rotated by one place toward the MSB: bit i takes bit i-1, and bit 0 takes the previous MSB.
- R5: For run patterns WIDTH+1 through 3·WIDTH-1, the shift runs the same way, but bit 0 takes the inverse of the previous MSB.
- R6: Seeds are visited in ascending index order. Two consecutive runs are separated by exactly one load cycle with `valid_o` and `done_o` both low.
- R7: After the last run, `done_o` goes high and `valid_o` low. `pattern_o` then holds, equal to the last seed, until the next start.
- R8: A start pulse in any state, including the middle of a run or after completion, restarts the sweep from seed 0 with a load cycle and clears `done_o`.
- R9: `valid_o` and `done_o` are never high in the same cycle.
- R10: Before the first start the block stays idle, with every output at its reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts or restarts the seed sweep |
| pattern_o | output | WIDTH | Current contents of the pattern register |
| valid_o | output | 1 | High when `pattern_o` is a stimulus for the core |
| done_o | output | 1 | High once every seed has been run, until the next start |

## Verification
On every clock, the assertions check the step rule between consecutive valid patterns: a plain rotation for the first WIDTH steps of a run and an inverted wrap afterwards. They also check that no run exceeds 3·WIDTH patterns, that the load gap follows a start, that the outputs stay frozen while finished, and that `valid_o` and `done_o` never overlap. The bench scenarios alone can show that each run starts from the correct table entry, in ascending order, with exactly 3·WIDTH patterns. They also show that a restart in mid-run or after completion resumes at seed 0, and that the idle state holds until the first start.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } tpg_state_e;

    // Selector code driving every per-bit four-way mux.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_RING  = 2'd2,
        MODE_TWIST = 2'd3
    } tpg_mode_e;

endpackage

// File: rtl/tpg_seed_rom.sv
module tpg_seed_rom #(
    parameter int unsigned WIDTH     = 8,
    parameter int unsigned NUM_SEEDS = 4,
    parameter int unsigned IDX_W     = 2,
    parameter logic [NUM_SEEDS*WIDTH-1:0] SEED_TABLE = '0
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [WIDTH-1:0] seed_o
);

    logic [WIDTH-1:0] entry [NUM_SEEDS];

    for (genvar k = 0; k < NUM_SEEDS; k++) begin : g_entry
        assign entry[k] = SEED_TABLE[k*WIDTH +: WIDTH];
    end

    always_comb begin
        seed_o = '0;
        for (int k = 0; k < NUM_SEEDS; k++) begin
            if (idx_i == IDX_W'(k)) begin
                seed_o = entry[k];
            end
        end
    end

endmodule

// File: rtl/tpg_sequencer.sv
module tpg_sequencer
    import tpg_pkg::*;
#(
    parameter int unsigned WIDTH     = 8,
    parameter int unsigned NUM_SEEDS = 4,
    parameter int unsigned IDX_W     = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output tpg_mode_e        mode_o,
    output logic [IDX_W-1:0] seed_idx_o,
    output logic             valid_o,
    output logic             done_o
);

    localparam int unsigned RUN_LEN = 3 * WIDTH;
    localparam int unsigned PHASE_W = $clog2(RUN_LEN);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(RUN_LEN - 1);
    localparam logic [PHASE_W-1:0] TWIST_FROM = PHASE_W'(WIDTH);
    localparam logic [IDX_W-1:0]   LAST_IDX   = IDX_W'(NUM_SEEDS - 1);

    typedef struct packed {
        tpg_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic [PHASE_W-1:0] phase;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        mode_o = MODE_HOLD;
        unique case (seq_q.st)
            ST_IDLE: mode_o = MODE_HOLD;
            ST_LOAD: begin
                mode_o      = MODE_LOAD;
                seq_d.st    = ST_RUN;
                seq_d.phase = '0;
            end
            ST_RUN: begin
                mode_o = (seq_q.phase < TWIST_FROM) ? MODE_RING : MODE_TWIST;
                if (seq_q.phase == LAST_PHASE) begin
                    seq_d.phase = '0;
                    if (seq_q.idx == LAST_IDX) begin
                        seq_d.st = ST_DONE;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                        seq_d.st  = ST_LOAD;
                    end
                end else begin
                    seq_d.phase = seq_q.phase + 1'b1;
                end
            end
            ST_DONE: mode_o = MODE_HOLD;
            default: mode_o = MODE_HOLD;
        endcase
        if (start_i) begin
            seq_d.st    = ST_LOAD;
            seq_d.idx   = '0;
            seq_d.phase = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: ST_IDLE, idx: '0, phase: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign seed_idx_o = seq_q.idx;
    assign valid_o    = (seq_q.st == ST_RUN);
    assign done_o     = (seq_q.st == ST_DONE);

endmodule

// File: rtl/tpg_shift_reg.sv
module tpg_shift_reg
    import tpg_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  tpg_mode_e        mode_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] pattern_o
);

    logic [WIDTH-1:0] reg_d, reg_q;
    logic [WIDTH-1:0] bit_nxt;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic ring_in, twist_in;
        if (i == 0) begin : g_head
            assign ring_in  = reg_q[WIDTH-1];
            assign twist_in = ~reg_q[WIDTH-1];
        end else begin : g_body
            assign ring_in  = reg_q[i-1];
            assign twist_in = reg_q[i-1];
        end
        always_comb begin
            unique case (mode_i)
                MODE_LOAD:  bit_nxt[i] = seed_i[i];
                MODE_RING:  bit_nxt[i] = ring_in;
                MODE_TWIST: bit_nxt[i] = twist_in;
                default:    bit_nxt[i] = reg_q[i];
            endcase
        end
    end

    always_comb begin
        reg_d = bit_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign pattern_o = reg_q;

endmodule

// File: rtl/tpg_johnson_gen.sv
module tpg_johnson_gen
    import tpg_pkg::*;
#(
    parameter int unsigned WIDTH     = 8,
    parameter int unsigned NUM_SEEDS = 4,
    parameter logic [NUM_SEEDS*WIDTH-1:0] SEED_TABLE =
        {NUM_SEEDS{ {WIDTH{1'b1}} >> (WIDTH / 2) }}
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic [WIDTH-1:0] pattern_o,
    output logic             valid_o,
    output logic             done_o
);

    localparam int unsigned IDX_W = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1;

    tpg_mode_e        mode;
    logic [IDX_W-1:0] seed_idx;
    logic [WIDTH-1:0] seed;

    tpg_sequencer #(
        .WIDTH     (WIDTH),
        .NUM_SEEDS (NUM_SEEDS),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .mode_o     (mode),
        .seed_idx_o (seed_idx),
        .valid_o    (valid_o),
        .done_o     (done_o)
    );

    tpg_seed_rom #(
        .WIDTH      (WIDTH),
        .NUM_SEEDS  (NUM_SEEDS),
        .IDX_W      (IDX_W),
        .SEED_TABLE (SEED_TABLE)
    ) u_rom (
        .idx_i  (seed_idx),
        .seed_o (seed)
    );

    tpg_shift_reg #(
        .WIDTH (WIDTH)
    ) u_reg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_i    (mode),
        .seed_i    (seed),
        .pattern_o (pattern_o)
    );

endmodule

// File: rtl/tpg_johnson_gen_chk.sv
module tpg_johnson_gen_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [WIDTH-1:0] pattern_o,
    input logic             valid_o,
    input logic             done_o
);

    localparam int unsigned RUN_LEN = 3 * WIDTH;
    localparam int unsigned CNT_W   = $clog2(RUN_LEN + 1) + 1;

    // Number of consecutive valid cycles seen before the current one.
    logic [CNT_W-1:0] streak_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            streak_q <= '0;
            prev_q   <= '0;
        end else begin
            streak_q <= valid_o ? streak_q + 1'b1 : '0;
            prev_q   <= pattern_o;
        end
    end

    assert_flags_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_o && done_o));

    assert_load_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> !valid_o && !done_o);

    assert_ring_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && streak_q >= 1 && streak_q <= CNT_W'(WIDTH))
        |-> pattern_o == {prev_q[WIDTH-2:0], prev_q[WIDTH-1]});

    assert_twist_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && streak_q > CNT_W'(WIDTH))
        |-> pattern_o == {prev_q[WIDTH-2:0], ~prev_q[WIDTH-1]});

    assert_run_length_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> streak_q < CNT_W'(RUN_LEN));

    assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && $past(done_o) && !$past(start_i)) |-> $stable(pattern_o));

endmodule

bind tpg_johnson_gen tpg_johnson_gen_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .pattern_o (pattern_o),
    .valid_o   (valid_o),
    .done_o    (done_o)
);

// File: tb/tpg_johnson_gen_tb_top.sv
`timescale 1ns/1ps
module tpg_johnson_gen_tb_top;

    localparam int W = 5;
    localparam int S = 3;
    localparam logic [S*W-1:0] TABLE = {5'b01101, 5'b10110, 5'b00001};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] pattern;
    logic         valid;
    logic         done;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    tpg_johnson_gen #(
        .WIDTH      (W),
        .NUM_SEEDS  (S),
        .SEED_TABLE (TABLE)
    ) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .pattern_o (pattern),
        .valid_o   (valid),
        .done_o    (done)
    );

    function automatic logic [W-1:0] seed_of(int k);
        return TABLE[k*W +: W];
    endfunction

    function automatic logic [W-1:0] rotl(logic [W-1:0] s, int k);
        logic [2*W-1:0] wide;
        wide = {s, s} << k;
        return wide[2*W-1:W];
    endfunction

    // Value after j twisted steps from s (0 <= j < 2W).
    function automatic logic [W-1:0] twisted(logic [W-1:0] s, int j);
        logic [W-1:0] mask;
        int jj;
        jj = (j > W) ? j - W : j;
        mask = W'((32'd1 << jj) - 1);
        if (j > W) return ~(rotl(s, jj) ^ mask);
        return rotl(s, jj) ^ mask;
    endfunction

    function automatic logic [W-1:0] expected(logic [W-1:0] s, int k);
        if (k <= W) return rotl(s, k % W);
        return twisted(s, k - W);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R2 load cycle valid", 32'(valid), 32'd0);
        check("R8 done cleared", 32'(done), 32'd0);
    endtask

    task automatic check_run(int k, int cycles);
        for (int p = 0; p < cycles; p++) begin
            @(negedge clk);
            check("R3 valid in run", 32'(valid), 32'd1);
            if (p == 0)      check("R3 run starts at seed", 32'(pattern), 32'(seed_of(k)));
            else if (p <= W) check("R4 ring step", 32'(pattern), 32'(expected(seed_of(k), p)));
            else             check("R5 twist step", 32'(pattern), 32'(expected(seed_of(k), p)));
            check("R9 no done in run", 32'(done), 32'd0);
        end
    endtask

    task automatic full_sweep();
        for (int k = 0; k < S; k++) begin
            check_run(k, 3 * W);
            @(negedge clk);
            if (k < S - 1) begin
                check("R6 load gap valid", 32'(valid), 32'd0);
                check("R6 load gap done", 32'(done), 32'd0);
            end else begin
                check("R7 done raised", 32'(done), 32'd1);
                check("R7 valid low", 32'(valid), 32'd0);
                check("R7 holds last seed", 32'(pattern), 32'(seed_of(S - 1)));
            end
        end
        for (int h = 0; h < 4; h++) begin
            @(negedge clk);
            check("R7 hold done", 32'(done), 32'd1);
            check("R9 hold valid", 32'(valid), 32'd0);
            check("R7 hold pattern", 32'(pattern), 32'(seed_of(S - 1)));
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(valid), 32'd0);
        check("R1 reset done", 32'(done), 32'd0);
        check("R1 reset pattern", 32'(pattern), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset pattern", 32'(pattern), 32'd0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R10 idle valid", 32'(valid), 32'd0);
            check("R10 idle done", 32'(done), 32'd0);
            check("R10 idle pattern", 32'(pattern), 32'd0);
        end

        pulse_start();
        full_sweep();

        // R8: restart after completion
        pulse_start();
        full_sweep();

        // R8: restart in mid-run (seed 0, pattern 7)
        pulse_start();
        check_run(0, 7);
        pulse_start();
        full_sweep();

        // R8: restart during second seed
        pulse_start();
        check_run(0, 3 * W);
        @(negedge clk);
        check("R6 gap before seed 1", 32'(valid), 32'd0);
        check_run(1, 4);
        pulse_start();
        full_sweep();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule